// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

This block is a chain of 4-bit synchronous binary up-counter stages that together behave as one wide counter. All state updates on the rising clock edge. The counter can be preset from a parallel data bus through an active-low load, cleared through an active-low clear, and advanced by two count enables. The first enable (P) is shared by every stage. The second enable (T) also gates the terminal-count carry, so it can be fed forward along the chain.

Inside the wrapper, each stage's carry drives the T input of the stage above it. No extra gating is needed: the whole chain counts as one binary counter. The final carry is brought out so that further wrappers can be chained the same way. A parameter selects whether the clear acts at the next clock edge or at once, without waiting for the clock. A synchronous active-high reset puts every stage at zero.

Top module: `cascade_counter`

## Requirements
- R1: With rst low, clr_n high, load_n high and both en_p and en_t high at a rising edge, q becomes q+1 modulo 2^W. The value 2^W-1 wraps to 0.
- R2: With rst low, clr_n high and load_n high, if en_p or en_t is low at a rising edge, q keeps its value.
- R3: With rst low, clr_n high and load_n low, the next rising edge copies din into q whatever the levels of en_p and en_t.
- R4: A low clr_n zeroes q ahead of load and count. When ASYNC_CLR is 0 this happens at the next rising edge. When ASYNC_CLR is 1 it happens as soon as clr_n falls, without waiting for a clock edge.
- R5: rco is high exactly when en_t is high and every bit of q is 1. With en_t low, rco is low for every count.
- R6: Counting crosses each 4-bit stage boundary in a single edge. For example, 0x0F goes to 0x10, and 0xFF goes to 0x00 with rco high while q is 0xFF.
- R7: rst high at a rising edge sets q to 0. It takes priority over clear, load and count.
- R8: en_p does not gate the carry. With en_p low, en_t high and q all ones, q holds and rco stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for every stage |
| rst | input | 1 | Synchronous active-high reset to zero |
| clr_n | input | 1 | Active-low clear; synchronous or asynchronous according to ASYNC_CLR |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_p | input | 1 | Count enable shared by all stages |
| en_t | input | 1 | Count enable that also gates the carry output |
| din | input | W (4*STAGES) | Parallel preset data |
| q | output | W (4*STAGES) | Count value |
| rco | output | 1 | Terminal-count carry for the next wrapper |

## Verification
Clear, load and count can all be requested at the same edge. The bench holds clr_n and load_n low together with both enables high, and expects zero. It also holds load_n low with both enables high, and expects exactly din rather than din+1. Carry and hold share the cycle at terminal count with en_p low: the bench expects the value held and rco high. A second instance with asynchronous clear is checked in the middle of a clock period, right after clr_n falls, while the synchronous instance must still show its old value.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;

    localparam int NIB_W = 4;

    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } stage_op_e;

    // Priority: clear, then load, then count, then hold.
    function automatic stage_op_e pick_op(input logic clr_n, input logic load_n,
                                          input logic en_p, input logic en_t);
        if (!clr_n)
            return OP_CLEAR;
        else if (!load_n)
            return OP_LOAD;
        else if (en_p && en_t)
            return OP_COUNT;
        else
            return OP_HOLD;
    endfunction

    function automatic nib_t nib_next(input stage_op_e op, input nib_t cur, input nib_t din);
        case (op)
            OP_CLEAR: return '0;
            OP_LOAD:  return din;
            OP_COUNT: return cur + nib_t'(1);
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/ctr_tc_decode.sv
module ctr_tc_decode
    import cascade_counter_pkg::*;
(
    input  nib_t state,
    input  logic en_t,
    output logic carry
);
    // Single AND of the state bits: only one term, so no hazard between counts.
    always_comb carry = en_t & (&state);
endmodule

// File: rtl/ctr_stage.sv
module ctr_stage
    import cascade_counter_pkg::*;
#(
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_n,
    input  logic load_n,
    input  logic en_p,
    input  logic en_t,
    input  nib_t din,
    output nib_t q,
    output logic carry
);
    nib_t      state_r;
    stage_op_e op;
    nib_t      state_nx;

    always_comb begin
        op       = pick_op(clr_n, load_n, en_p, en_t);
        state_nx = nib_next(op, state_r, din);
    end

    generate
        if (ASYNC_CLR) begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    state_r <= '0;
                else if (rst)
                    state_r <= '0;
                else
                    state_r <= state_nx;
            end
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                if (rst)
                    state_r <= '0;
                else
                    state_r <= state_nx;
            end
        end
    endgenerate

    assign q = state_r;

    ctr_tc_decode u_tc (
        .state (state_r),
        .en_t  (en_t),
        .carry (carry)
    );
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import cascade_counter_pkg::*;
#(
    parameter int STAGES    = 2,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr_n,
    input  logic                      load_n,
    input  logic                      en_p,
    input  logic                      en_t,
    input  logic [STAGES*NIB_W-1:0]   din,
    output logic [STAGES*NIB_W-1:0]   q,
    output logic                      rco
);
    localparam int W = STAGES * NIB_W;

    // t_chain[i] is the T input of stage i; t_chain[STAGES] is the final carry.
    logic [STAGES:0] t_chain;

    assign t_chain[0] = en_t;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            ctr_stage #(.ASYNC_CLR(ASYNC_CLR)) u_stage (
                .clk    (clk),
                .rst    (rst),
                .clr_n  (clr_n),
                .load_n (load_n),
                .en_p   (en_p),
                .en_t   (t_chain[gi]),
                .din    (din[gi*NIB_W +: NIB_W]),
                .q      (q[gi*NIB_W +: NIB_W]),
                .carry  (t_chain[gi+1])
            );
        end
    endgenerate

    assign rco = t_chain[STAGES];

    logic unused_w;
    assign unused_w = (W == 0);
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
    parameter int W         = 8,
    parameter bit ASYNC_CLR = 1'b0
) (
    input logic         clk,
    input logic         rst,
    input logic         clr_n,
    input logic         load_n,
    input logic         en_p,
    input logic         en_t,
    input logic [W-1:0] din,
    input logic [W-1:0] q,
    input logic         rco
);
    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && load_n && en_p && en_t) |=> (!clr_n || q == W'($past(q) + 1'b1)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && load_n && !(en_p && en_t)) |=> (!clr_n || $stable(q)));

    // R3
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !load_n) |=> (!clr_n || q == $past(din)));

    // R5
    carry_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en_t |-> !rco);

    // R5
    carry_full_chk: assert property (@(posedge clk) disable iff (rst)
        rco |-> (&q));

    // R8
    carry_no_p_chk: assert property (@(posedge clk) disable iff (rst)
        (en_t && (&q)) |-> rco);

    // R7
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (q == '0));

    generate
        if (ASYNC_CLR) begin : g_async
            // R4
            clear_now_chk: assert property (@(posedge clk) disable iff (rst)
                !clr_n |-> (q == '0));
        end else begin : g_sync
            // R4
            clear_next_chk: assert property (@(posedge clk) disable iff (rst)
                !clr_n |=> (q == '0));
        end
    endgenerate
endmodule

bind cascade_counter cascade_counter_chk #(.W(W), .ASYNC_CLR(ASYNC_CLR)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .din    (din),
    .q      (q),
    .rco    (rco)
);

// File: tb/cascade_counter_tb.sv
`timescale 1ns/1ps
module cascade_counter_tb;
    localparam int STAGES = 2;
    localparam int W      = 4 * STAGES;
    localparam int MAXV   = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr_n = 1'b1;
    logic         load_n = 1'b1;
    logic         en_p = 1'b0;
    logic         en_t = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] q, qa;
    logic         rco, rcoa;

    int checks = 0;
    int fails  = 0;
    int mq     = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    cascade_counter #(.STAGES(STAGES), .ASYNC_CLR(1'b0)) u_dut (
        .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n),
        .en_p(en_p), .en_t(en_t), .din(din), .q(q), .rco(rco));

    cascade_counter #(.STAGES(STAGES), .ASYNC_CLR(1'b1)) u_async (
        .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n),
        .en_p(en_p), .en_t(en_t), .din(din), .q(qa), .rco(rcoa));

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: reference model follows the edge, then outputs are compared mid-cycle.
    task automatic step(input string req);
        bit exp_rco;
        @(posedge clk);
        if (rst)                 mq = 0;
        else if (!clr_n)         mq = 0;
        else if (!load_n)        mq = int'(din);
        else if (en_p && en_t)   mq = (mq + 1) % (MAXV + 1);
        @(negedge clk);
        exp_rco = en_t && (mq == MAXV);
        check(req, "q",    int'(q),    mq);
        check(req, "rco",  int'(rco),  int'(exp_rco));
        check(req, "qa",   int'(qa),   mq);
        check(req, "rcoa", int'(rcoa), int'(exp_rco));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R7: reset state
        step("R7");
        step("R7");
        rst = 1'b0;
        step("R2");

        // R1 / R6: count through the first stage boundary
        en_p = 1'b1; en_t = 1'b1;
        for (int i = 0; i < 20; i++) step("R1_R6");

        // R2: either enable low holds
        en_p = 1'b0;
        for (int i = 0; i < 3; i++) step("R2");
        en_p = 1'b1; en_t = 1'b0;
        for (int i = 0; i < 3; i++) step("R2");

        // R3: load with enables high loads din, not din+1
        en_t = 1'b1; load_n = 1'b0; din = 8'hFC;
        step("R3");
        load_n = 1'b1;
        // R6 / R5 / R1: run through 0xFF and wrap to 0
        for (int i = 0; i < 6; i++) step("R6");

        // R8: terminal count with en_p low, carry stays high
        load_n = 1'b0; din = 8'hFF; en_p = 1'b0;
        step("R3");
        load_n = 1'b1;
        for (int i = 0; i < 3; i++) step("R8");
        // R5: en_t low masks the carry at terminal count
        en_t = 1'b0;
        step("R5");
        en_t = 1'b1; en_p = 1'b1;
        step("R1");

        // R3: load with enables low
        en_p = 1'b0; en_t = 1'b0; load_n = 1'b0; din = 8'h3A;
        step("R3");
        load_n = 1'b1;
        step("R2");

        // R4: clear beats load and count in the same cycle
        en_p = 1'b1; en_t = 1'b1; clr_n = 1'b0; load_n = 1'b0; din = 8'h77;
        step("R4");
        clr_n = 1'b1; load_n = 1'b1;
        step("R1");

        // R4: asynchronous clear acts mid-cycle, synchronous waits for the edge
        load_n = 1'b0; din = 8'h55; en_p = 1'b0; en_t = 1'b0;
        step("R3");
        load_n = 1'b1;
        clr_n = 1'b0;
        #1;
        check("R4", "async q mid-cycle", int'(qa), 0);
        check("R4", "sync q mid-cycle",  int'(q),  8'h55);
        step("R4");
        clr_n = 1'b1;
        step("R2");

        // R7: reset beats load
        load_n = 1'b0; din = 8'hA5;
        step("R3");
        rst = 1'b1; din = 8'h11;
        step("R7");
        rst = 1'b0; load_n = 1'b1;
        step("R2");

        finish_run();
    end
endmodule